// File: doc/BRIEF.md
# Buffered Serial Configuration Port

This block is a serial slave that gives an external host access to a small bank of configuration registers. It works over three wires, with one shared bidirectional data line, or over four wires, with a separate data output. The serial clock, select and data lines are synchronised into the system clock, so the block runs entirely in the `clk_i` domain. Each access starts with a 16-bit command. The command carries a direction flag, a byte-count code and a 13-bit start address. Data bytes follow the command. Their number is either fixed at one, two or three, or open-ended until the select line is released. The address steps by one after every byte.

Writes to the configuration registers fill a shadow copy. The hardware sees only the active copy, which is exported on `cfg_o`. A write of 1 to bit 0 of the commit address moves every shadow byte into the active copy in a single clock. The host may therefore stage any number of bytes over many accesses before it commits them.

A port-control byte at address 0 takes effect at once. It selects the bit order, the output wire for read data, and whether reads return shadow or active contents. It also holds a sticky soft-reset bit.

Top module: `spi_cfg_port`

## Requirements
- R1: A command is 16 bits. Bit 15 is the direction (1 = read), bits 14:13 are the count code, and bits 12:0 are the start address. By default the command is shifted in bit 15 first, and data bytes bit 7 first.
- R2: Count codes 00, 01 and 10 move exactly 1, 2 and 3 data bytes. Further bytes clocked in under the same select are ignored.
- R3: Count code 11 streams bytes until select rises. It steps through every address in turn, including unmapped ones and the commit address.
- R4: With control bit 1 = 0, the address decrements after each byte, and the 13-bit address wraps from 0 to 8191. With control bit 1 = 1, command and data bits are shifted least significant bit first and the address increments. The order is taken when select falls.
- R5: A write to a configuration address (1 to NUM_REGS-2) changes only the shadow copy. `cfg_o` (byte k-1 holds address k) is unchanged until a commit.
- R6: Writing a byte with bit 0 = 1 to address NUM_REGS-1 copies all shadow bytes to the active copy at once. Reading that address always returns 0.
- R7: Bytes staged by several separate write accesses all reach `cfg_o` with a single commit.
- R8: Control bit 2 is a soft reset. While it is 1, shadow and active bytes hold their defaults (0xA0 XOR address) and shadow writes and commits are ignored. The bit stays set until it is written back to 0. Hard reset also loads these defaults and clears the control byte.
- R9: Control bit 3 selects the read source for configuration addresses: 0 returns the shadow byte and 1 returns the active byte. A read of address 0 returns the control byte.
- R10: If select rises before the eighth bit of a data byte, that partial byte is discarded.
- R11: With control bit 0 = 0, read data is driven on `sdio_o` with `sdio_oe_o` high. With control bit 0 = 1, read data appears on `sdo_o` and `sdio_oe_o` stays low. Each read bit changes after a serial clock rising edge and is valid at the next rising edge.
- R12: Writes to addresses above NUM_REGS-1 have no effect, and reads of those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Serial select, active low |
| sclk_i | input | 1 | Serial clock; data sampled on its rising edge |
| sdio_i | input | 1 | Serial data in (command and write data) |
| sdio_o | output | 1 | Read data on the shared line in three-wire mode |
| sdio_oe_o | output | 1 | Output enable for the shared data line |
| sdo_o | output | 1 | Read data in four-wire mode |
| cfg_o | output | 8*(NUM_REGS-2) | Active configuration bytes |

## Verification
Every configuration address is written with a value computed from its address, committed, and then overwritten in the shadow copy only. Reads in both bit orders and from both read sources then show whether shadow and active contents are kept apart, and whether the address steps the right way. Fixed-count accesses carry extra bytes, which show whether the count code is obeyed. Streams cross the commit address, unmapped addresses and the zero wrap, which shows that no address is skipped or aliased. An access cut off mid-byte, a soft-reset sequence and four-wire reads cover the discard rule, the sticky reset and the choice of output wire.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam int CMD_W  = 16;
  localparam int ADDR_W = 13;
  localparam int BYTE_W = 8;

  // control byte bit positions
  localparam int CB_SDO   = 0;
  localparam int CB_LSB   = 1;
  localparam int CB_SRST  = 2;
  localparam int CB_RDACT = 3;

  localparam logic [1:0] CNT_STREAM = 2'b11;

  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_DATA = 2'd1,
    PH_DONE = 2'd2
  } phase_e;

  function automatic logic [BYTE_W-1:0] reg_default(input int idx);
    return 8'hA0 ^ 8'(idx);
  endfunction
endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic cs_ni,
  input  logic sdio_i,
  output logic sclk_rise_o,
  output logic cs_act_o,
  output logic sd_o
);
  logic [STAGES-1:0] sclk_q, cs_q, sd_q;
  logic sclk_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= '0;
      cs_q   <= '1;
      sd_q   <= '0;
      sclk_d <= 1'b0;
    end else begin
      sclk_q <= {sclk_q[STAGES-2:0], sclk_i};
      cs_q   <= {cs_q[STAGES-2:0], cs_ni};
      sd_q   <= {sd_q[STAGES-2:0], sdio_i};
      sclk_d <= sclk_q[STAGES-1];
    end
  end

  // data travels the same depth as the clock, so it lines up with the edge
  assign sclk_rise_o = sclk_q[STAGES-1] & ~sclk_d;
  assign cs_act_o    = ~cs_q[STAGES-1];
  assign sd_o        = sd_q[STAGES-1];
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
  import spi_cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_rise_i,
  input  logic              cs_act_i,
  input  logic              sd_i,
  input  logic              lsb_first_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              bit_o,
  output logic              drive_o
);
  phase_e            phase_q;
  logic [3:0]        bit_cnt_q;
  logic [CMD_W-1:0]  cmd_q, cmd_nxt;
  logic [BYTE_W-1:0] byte_q, byte_nxt, rd_byte_q;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        cnt_q, left_q;
  logic              lsb_q, rd_q, load_q;
  logic              cmd_end, byte_end;

  always_comb begin
    cmd_nxt  = lsb_q ? {sd_i, cmd_q[CMD_W-1:1]}   : {cmd_q[CMD_W-2:0], sd_i};
    byte_nxt = lsb_q ? {sd_i, byte_q[BYTE_W-1:1]} : {byte_q[BYTE_W-2:0], sd_i};
    cmd_end  = sclk_rise_i && cs_act_i && phase_q == PH_CMD  && bit_cnt_q == 4'd15;
    byte_end = sclk_rise_i && cs_act_i && phase_q == PH_DATA && bit_cnt_q[2:0] == 3'd7;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_CMD;
      bit_cnt_q <= '0;
      cmd_q     <= '0;
      byte_q    <= '0;
      rd_byte_q <= '0;
      addr_q    <= '0;
      cnt_q     <= '0;
      left_q    <= '0;
      lsb_q     <= 1'b0;
      rd_q      <= 1'b0;
      load_q    <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (load_q) begin
        rd_byte_q <= rd_data_i;
        load_q    <= 1'b0;
      end
      if (!cs_act_i) begin
        phase_q   <= PH_CMD;
        bit_cnt_q <= '0;
        lsb_q     <= lsb_first_i;
      end else if (sclk_rise_i) begin
        case (phase_q)
          PH_CMD: begin
            cmd_q     <= cmd_nxt;
            bit_cnt_q <= bit_cnt_q + 4'd1;
            if (cmd_end) begin
              phase_q   <= PH_DATA;
              bit_cnt_q <= '0;
              rd_q      <= cmd_nxt[15];
              cnt_q     <= cmd_nxt[14:13];
              left_q    <= cmd_nxt[14:13];
              addr_q    <= cmd_nxt[ADDR_W-1:0];
              load_q    <= 1'b1;
            end
          end
          PH_DATA: begin
            byte_q    <= byte_nxt;
            bit_cnt_q <= bit_cnt_q + 4'd1;
            if (byte_end) begin
              bit_cnt_q <= '0;
              wr_en_o   <= ~rd_q;
              wr_addr_o <= addr_q;
              wr_data_o <= byte_nxt;
              addr_q    <= lsb_q ? addr_q + ADDR_W'(1) : addr_q - ADDR_W'(1);
              load_q    <= 1'b1;
              if (cnt_q != CNT_STREAM) begin
                if (left_q == 2'd0) phase_q <= PH_DONE;
                else left_q <= left_q - 2'd1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_addr_o = addr_q;
  assign bit_o     = rd_byte_q[lsb_q ? bit_cnt_q[2:0] : ~bit_cnt_q[2:0]];
  assign drive_o   = cs_act_i && phase_q == PH_DATA && rd_q;

  a_r10_commit_needs_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(cs_act_i));
  a_r2_done_is_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_DONE && $past(phase_q) == PH_DONE) |-> (!wr_en_o && !drive_o));
  a_r1_command_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_DATA && $past(phase_q) == PH_CMD) |-> $past(bit_cnt_q) == 4'd15);
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_cfg_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [ADDR_W-1:0]            wr_addr_i,
  input  logic [BYTE_W-1:0]            wr_data_i,
  input  logic [ADDR_W-1:0]            rd_addr_i,
  output logic [BYTE_W-1:0]            rd_data_o,
  output logic                         sdo_sel_o,
  output logic                         lsb_first_o,
  output logic [(NUM_REGS-2)*BYTE_W-1:0] cfg_o
);
  localparam int LAST     = NUM_REGS - 2;
  localparam int UPD_ADDR = NUM_REGS - 1;
  localparam int CFG_W    = LAST * BYTE_W;

  logic [3:0]        ctrl_q;
  logic [BYTE_W-1:0] buf_q [1:LAST];
  logic [BYTE_W-1:0] act_q [1:LAST];
  logic [CFG_W-1:0]  buf_flat, dflt_flat;
  logic              soft_rst, commit;

  assign soft_rst = ctrl_q[CB_SRST];
  assign commit   = wr_en_i && wr_addr_i == ADDR_W'(UPD_ADDR) && wr_data_i[0] && !soft_rst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             ctrl_q <= '0;
    else if (wr_en_i && wr_addr_i == '0)     ctrl_q <= wr_data_i[3:0];
  end

  for (genvar g = 1; g <= LAST; g++) begin : g_reg
    localparam logic [BYTE_W-1:0] DV = reg_default(g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        buf_q[g] <= DV;
        act_q[g] <= DV;
      end else if (soft_rst) begin
        buf_q[g] <= DV;
        act_q[g] <= DV;
      end else begin
        if (wr_en_i && wr_addr_i == ADDR_W'(g)) buf_q[g] <= wr_data_i;
        if (commit) act_q[g] <= buf_q[g];
      end
    end
    assign cfg_o[(g-1)*BYTE_W +: BYTE_W]     = act_q[g];
    assign buf_flat[(g-1)*BYTE_W +: BYTE_W]  = buf_q[g];
    assign dflt_flat[(g-1)*BYTE_W +: BYTE_W] = DV;
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == '0) rd_data_o = {4'b0, ctrl_q};
    for (int i = 1; i <= LAST; i++)
      if (rd_addr_i == ADDR_W'(i))
        rd_data_o = ctrl_q[CB_RDACT] ? act_q[i] : buf_q[i];
  end

  assign sdo_sel_o   = ctrl_q[CB_SDO];
  assign lsb_first_o = ctrl_q[CB_LSB];

  a_r6_commit_copies_shadow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> cfg_o == $past(buf_flat));
  a_r5_active_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!commit && !soft_rst) |=> $stable(cfg_o));
  a_r8_soft_reset_defaults: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> (cfg_o == dflt_flat && buf_flat == dflt_flat));
endmodule

// File: rtl/spi_cfg_port.sv
module spi_cfg_port
  import spi_cfg_pkg::*;
#(
  parameter int NUM_REGS    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           cs_ni,
  input  logic                           sclk_i,
  input  logic                           sdio_i,
  output logic                           sdio_o,
  output logic                           sdio_oe_o,
  output logic                           sdo_o,
  output logic [(NUM_REGS-2)*BYTE_W-1:0] cfg_o
);
  logic              sclk_rise, cs_act, sd;
  logic              wr_en, bit_val, drive, sdo_sel, lsb_first;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [BYTE_W-1:0] wr_data, rd_data;

  spi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .sclk_i(sclk_i), .cs_ni(cs_ni), .sdio_i(sdio_i),
    .sclk_rise_o(sclk_rise), .cs_act_o(cs_act), .sd_o(sd));

  spi_xfer_engine u_engine (
    .clk_i(clk_i), .rst_ni(rst_ni), .sclk_rise_i(sclk_rise), .cs_act_i(cs_act), .sd_i(sd),
    .lsb_first_i(lsb_first), .rd_data_i(rd_data), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .rd_addr_o(rd_addr), .bit_o(bit_val), .drive_o(drive));

  spi_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .sdo_sel_o(sdo_sel), .lsb_first_o(lsb_first),
    .cfg_o(cfg_o));

  assign sdio_oe_o = drive & ~sdo_sel;
  assign sdio_o    = drive & ~sdo_sel & bit_val;
  assign sdo_o     = drive & sdo_sel & bit_val;

  a_r11_one_wire_driven: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdo_o |-> !sdio_oe_o);
endmodule

// File: tb/spi_cfg_port_bench.sv
module spi_cfg_port_bench;
  localparam int NR   = 16;
  localparam int LAST = NR - 2;
  localparam int HALF = 6;

  logic clk = 1'b0, rst_ni = 1'b0, cs_ni = 1'b1, sclk_i = 1'b0, sdio_i = 1'b0;
  logic sdio_o, sdio_oe_o, sdo_o;
  logic [LAST*8-1:0] cfg_o;

  spi_cfg_port #(.NUM_REGS(NR)) u_spi_cfg_port (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .sclk_i(sclk_i), .sdio_i(sdio_i),
    .sdio_o(sdio_o), .sdio_oe_o(sdio_oe_o), .sdo_o(sdo_o), .cfg_o(cfg_o));

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [7:0] m_buf [0:NR-1];
  logic [7:0] m_act [0:NR-1];
  logic [3:0] m_ctrl = '0;
  logic tb_lsb = 1'b0, use_sdo = 1'b0, oe_seen;
  logic [7:0] tx_q [0:31];
  logic [7:0] rx_q [0:31];

  function automatic logic [7:0] dflt(input int i);
    return 8'hA0 ^ 8'(i);
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic chk_cfg(input string tag);
    for (int i = 1; i <= LAST; i++) chk(tag, cfg_o[(i-1)*8 +: 8], m_act[i]);
  endtask

  function automatic logic [7:0] exp_rd(input logic [12:0] a);
    if (a == 0) return {4'b0, m_ctrl};
    if (a >= 1 && a <= LAST) return m_ctrl[3] ? m_act[a] : m_buf[a];
    return 8'h00;
  endfunction

  task automatic model_wr(input logic [12:0] a, input logic [7:0] d);
    if (a == 0) m_ctrl = d[3:0];
    else if (a >= 1 && a <= LAST) begin
      if (!m_ctrl[2]) m_buf[a] = d;
    end else if (a == NR - 1) begin
      if (d[0] && !m_ctrl[2]) for (int i = 1; i <= LAST; i++) m_act[i] = m_buf[i];
    end
    if (m_ctrl[2]) for (int i = 1; i <= LAST; i++) begin
      m_buf[i] = dflt(i);
      m_act[i] = dflt(i);
    end
  endtask

  task automatic send(input logic b, output logic o);
    sdio_i = b;
    repeat (HALF) @(posedge clk);
    #1;
    o = use_sdo ? sdo_o : sdio_o;
    if (sdio_oe_o) oe_seen = 1'b1;
    sclk_i = 1'b1;
    repeat (HALF) @(posedge clk);
    #1;
    sclk_i = 1'b0;
  endtask

  task automatic xfer(input string tag, input logic rd, input logic [1:0] cnt,
                      input logic [12:0] addr, input int nb, input int extra);
    logic [15:0] cmd;
    logic [12:0] a;
    logic o, exp_oe;
    int ncommit;
    cmd = {rd, cnt, addr};
    oe_seen = 1'b0;
    #1;
    cs_ni = 1'b0;
    repeat (HALF) @(posedge clk);
    #1;
    for (int k = 0; k < 16; k++) send(tb_lsb ? cmd[k] : cmd[15-k], o);
    for (int b = 0; b < nb; b++)
      for (int k = 0; k < 8; k++) begin
        send(tx_q[b][tb_lsb ? k : 7-k], o);
        rx_q[b][tb_lsb ? k : 7-k] = o;
      end
    for (int k = 0; k < extra; k++) send(tx_q[nb][tb_lsb ? k : 7-k], o);
    repeat (HALF) @(posedge clk);
    #1;
    cs_ni = 1'b1;
    repeat (4*HALF) @(posedge clk);
    #1;
    ncommit = (cnt == 2'b11) ? nb : ((nb < int'(cnt) + 1) ? nb : int'(cnt) + 1);
    exp_oe  = rd && ncommit > 0 && !m_ctrl[0];
    chk({tag, " oe"}, {7'b0, oe_seen}, {7'b0, exp_oe});
    a = addr;
    for (int b = 0; b < ncommit; b++) begin
      if (rd) chk(tag, rx_q[b], exp_rd(a));
      else    model_wr(a, tx_q[b]);
      a = tb_lsb ? a + 13'd1 : a - 13'd1;
    end
    tb_lsb  = m_ctrl[1];
    use_sdo = m_ctrl[0];
  endtask

  task automatic wr1(input string tag, input logic [12:0] a, input logic [7:0] d);
    tx_q[0] = d;
    xfer(tag, 1'b0, 2'b00, a, 1, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog got=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NR; i++) begin
      m_buf[i] = dflt(i);
      m_act[i] = dflt(i);
    end
    repeat (5) @(posedge clk);
    #1 rst_ni = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    chk_cfg("R8 reset defaults");
    chk("R11 idle oe", {7'b0, sdio_oe_o}, 8'h00);

    wr1("R5 single write", 13'd3, 8'h5A);
    chk_cfg("R5 shadow only");
    xfer("R1 R9 read shadow", 1'b1, 2'b00, 13'd3, 1, 0);
    wr1("R6 commit", 13'd15, 8'h01);
    chk_cfg("R6 active after commit");
    xfer("R6 commit reads zero", 1'b1, 2'b00, 13'd15, 1, 0);

    tx_q[0] = 8'h11; tx_q[1] = 8'h22; tx_q[2] = 8'h33; tx_q[3] = 8'h44;
    xfer("R2 three bytes", 1'b0, 2'b10, 13'd9, 4, 0);
    tx_q[0] = 8'h55; tx_q[1] = 8'h66;
    xfer("R2 two bytes", 1'b0, 2'b01, 13'd12, 2, 0);
    tx_q[0] = 8'h77; tx_q[1] = 8'h88;
    xfer("R2 one byte limit", 1'b0, 2'b00, 13'd5, 2, 0);
    chk_cfg("R7 staged not active");
    wr1("R7 commit", 13'd15, 8'h01);
    chk_cfg("R7 all staged active");

    xfer("R3 R4 stream read down wrap", 1'b1, 2'b11, 13'd14, 16, 0);
    wr1("R9 select active", 13'd0, 8'h08);
    xfer("R9 read active", 1'b1, 2'b11, 13'd14, 15, 0);
    wr1("R9 select shadow", 13'd0, 8'h00);

    wr1("R4 lsb on", 13'd0, 8'h02);
    tx_q[0] = 8'h71; tx_q[1] = 8'h72; tx_q[2] = 8'h00; tx_q[3] = 8'h74; tx_q[4] = 8'h75;
    xfer("R3 R12 stream write up", 1'b0, 2'b11, 13'd13, 5, 0);
    chk_cfg("R12 unmapped writes ignored");
    xfer("R4 R12 lsb read up", 1'b1, 2'b11, 13'd12, 6, 0);
    wr1("R4 lsb commit", 13'd15, 8'h01);
    chk_cfg("R4 lsb commit");
    wr1("R4 lsb off", 13'd0, 8'h00);

    tx_q[0] = 8'h99;
    xfer("R10 abort", 1'b0, 2'b00, 13'd4, 0, 5);
    xfer("R10 partial discarded", 1'b1, 2'b00, 13'd4, 1, 0);

    wr1("R11 four wire on", 13'd0, 8'h01);
    xfer("R11 four wire read", 1'b1, 2'b01, 13'd3, 2, 0);
    wr1("R11 four wire off", 13'd0, 8'h00);

    wr1("R8 soft reset set", 13'd0, 8'h04);
    chk_cfg("R8 soft reset defaults");
    wr1("R8 write ignored", 13'd2, 8'h12);
    wr1("R8 commit ignored", 13'd15, 8'h01);
    xfer("R8 bit stays set", 1'b1, 2'b00, 13'd0, 1, 0);
    xfer("R8 shadow default", 1'b1, 2'b00, 13'd2, 1, 0);
    wr1("R8 soft reset clear", 13'd0, 8'h00);
    chk_cfg("R8 released");

    for (int a = 1; a <= LAST; a++) wr1("R5 sweep write", 13'(a), 8'(a*29 + 3));
    chk_cfg("R5 sweep shadow only");
    wr1("R6 sweep commit", 13'd15, 8'h01);
    chk_cfg("R6 sweep active");
    for (int a = 1; a <= LAST; a++) wr1("R7 sweep restage", 13'(a), 8'(a*53 + 7));
    for (int sel = 0; sel < 2; sel++)
      for (int ord = 0; ord < 2; ord++) begin
        wr1("R9 sweep ctrl", 13'd0, 8'((sel << 3) | (ord << 1)));
        xfer("R9 R4 sweep read", 1'b1, 2'b11, ord ? 13'd1 : 13'd14, LAST, 0);
      end
    wr1("R4 sweep restore", 13'd0, 8'h00);
    chk_cfg("R5 sweep active unchanged");

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule